// File: doc/BRIEF.md
# Dual-Direction Word FIFO with Burst Request Thresholds

This block buffers 32-bit data words between a card-side data engine and a host-side agent (a DMA channel or software). It holds two independent queues. The receive queue is filled by the card engine and emptied by host reads. The transmit queue is filled by host writes and emptied by the card engine. Every access moves one whole word.

For each direction the block raises a request that is sized for fixed eight-word bursts:
- The receive request goes high once at least half the queue is occupied, so a burst of reads will always find data.
- The transmit request stays high while fewer than half the entries are occupied, so a burst of writes will always find room.

An end-of-transfer input keeps the receive request high while any word remains. This lets a short tail, or one stray extra word, be drained until the empty flag shows.

Each direction also reports full, empty and almost-full flags at fixed bit positions of a status word. A synchronous clear empties both queues.

Top module: `burst_fifo_pair`

## Requirements
- R1: After reset, and in the cycle after `fifoClear` is high, both levels are 0, both empty flags are set, `rxReq` is 0 and `txReq` is 1. While `fifoClear` is high, all other inputs are ignored and `hostRdData` is loaded with zero.
- R2: Words pushed with `cardRxPush` are returned by host reads at `hostAddr`=0 in push order. `rxLevel` tracks the occupancy.
- R3: Words written by the host at `hostAddr`=1 are presented on `cardTxData` in write order. Each `cardTxPop` advances to the next word. `cardTxData` is zero while the transmit queue is empty.
- R4: `rxReq` is 1 whenever the receive queue holds 8 or more words.
- R5: `txReq` is 1 exactly when the transmit queue holds fewer than 8 words.
- R6: While `endOfXfer` is 1, `rxReq` is 1 whenever the receive queue holds at least one word. In all other cases, `rxReq` is 0 below 8 words.
- R7: In each status word, bit 7 is set at 16 words (full), bit 6 at 0 words (empty), and bit 10 at 15 or more words (almost full). All other bits are 0.
- R8: A host read of an empty receive queue loads zero into `hostRdData` and leaves the level unchanged.
- R9: A card push into a full receive queue is dropped, even if a host read happens in the same cycle. A host write into a full transmit queue is dropped. A card pop of an empty transmit queue has no effect.
- R10: A host read that succeeds places the head word on `hostRdData` at the next clock edge. The value then holds until the next read or clear.
- R11: A host write at `hostAddr`=0 changes nothing. A host read at `hostAddr`=1 loads zero into `hostRdData` and moves no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoClear | input | 1 | Synchronous clear of both queues |
| cardRxPush | input | 1 | Card engine pushes a received word |
| cardRxData | input | 32 | Word pushed into the receive queue |
| cardTxPop | input | 1 | Card engine consumes the transmit head word |
| cardTxData | output | 32 | Transmit head word, zero when empty |
| hostRdEn | input | 1 | Host read strobe |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 1 | Host port select: 0 receive, 1 transmit |
| hostWrData | input | 32 | Host write word |
| hostRdData | output | 32 | Registered host read word |
| endOfXfer | input | 1 | Transfer tail: force receive request while data remains |
| rxReq | output | 1 | Receive burst request |
| txReq | output | 1 | Transmit burst request |
| rxStatus | output | 16 | Receive status flags |
| txStatus | output | 16 | Transmit status flags |
| rxLevel | output | 5 | Receive queue occupancy |
| txLevel | output | 5 | Transmit queue occupancy |

## Verification
The bench builds the block with its default parameters: depth 16, burst threshold 8, almost-full level 15 and 32-bit words. At that depth, random phases that alternate between filling and draining reach full, almost-full, threshold and empty on both queues many times. This exercises both threshold edges of the requests and the drop rules at full and empty. Directed sequences cover the clear, the short tail under `endOfXfer`, and accesses at the wrong address.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;
  localparam int FULL_BIT  = 7;
  localparam int EMPTY_BIT = 6;
  localparam int AFULL_BIT = 10;

  typedef struct packed {
    logic clear;
    logic rxPush;
    logic rxPop;
    logic txPush;
    logic txPop;
    logic rdZero;
  } fifoStrobes_t;
endpackage

// File: rtl/fifo_lane.sv
module fifo_lane #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wrPtr] <= wrData;
  end

  assign head = mem[rdPtr];

  // R9: the control never pushes into a full lane
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (level < LW'(DEPTH)));
  // R2: occupancy moves by one per accepted push
  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && !clear) |=> (level == $past(level) + 1'b1));
endmodule

// File: rtl/fifo_dp.sv
module fifo_dp
  import bfifo_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobes_t  stb,
  input  logic [W-1:0]  cardRxData,
  input  logic [W-1:0]  hostWrData,
  output logic [W-1:0]  cardTxData,
  output logic [W-1:0]  hostRdData,
  output logic [LW-1:0] rxLevel,
  output logic [LW-1:0] txLevel
);
  localparam int LANES = 2;

  logic          pushV  [LANES];
  logic          popV   [LANES];
  logic [W-1:0]  wrV    [LANES];
  logic [W-1:0]  headV  [LANES];
  logic [LW-1:0] levelV [LANES];

  assign pushV[0] = stb.rxPush;
  assign popV[0]  = stb.rxPop;
  assign wrV[0]   = cardRxData;
  assign pushV[1] = stb.txPush;
  assign popV[1]  = stb.txPop;
  assign wrV[1]   = hostWrData;

  generate
    for (genvar d = 0; d < LANES; d++) begin : g_lane
      fifo_lane #(.W(W), .DEPTH(DEPTH)) i_lane (
        .clk(clk), .rstN(rstN), .clear(stb.clear),
        .push(pushV[d]), .pop(popV[d]), .wrData(wrV[d]),
        .head(headV[d]), .level(levelV[d])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           hostRdData <= '0;
    else if (stb.rdZero) hostRdData <= '0;
    else if (stb.rxPop)  hostRdData <= headV[0];
  end

  assign cardTxData = (levelV[1] != '0) ? headV[1] : '0;
  assign rxLevel    = levelV[0];
  assign txLevel    = levelV[1];

  // R8: receive pops only happen on a non-empty queue
  assert_rx_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.rxPop |-> (levelV[0] != '0));
  // R9: transmit pops only happen on a non-empty queue
  assert_tx_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.txPop |-> (levelV[1] != '0));
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import bfifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int BURST  = DEPTH / 2,
  parameter int AFULL  = DEPTH - 1,
  parameter int STAT_W = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoClear,
  input  logic              cardRxPush,
  input  logic              cardTxPop,
  input  logic              hostRdEn,
  input  logic              hostWrEn,
  input  logic              hostAddr,
  input  logic              endOfXfer,
  input  logic [LW-1:0]     rxLevel,
  input  logic [LW-1:0]     txLevel,
  output fifoStrobes_t      stb,
  output logic              rxReq,
  output logic              txReq,
  output logic [STAT_W-1:0] rxStatus,
  output logic [STAT_W-1:0] txStatus
);
  localparam logic ADDR_RX = 1'b0;
  localparam logic ADDR_TX = 1'b1;

  logic rxFull, rxEmpty, txFull, txEmpty, rxRdOk;

  assign rxFull  = (rxLevel == LW'(DEPTH));
  assign rxEmpty = (rxLevel == '0);
  assign txFull  = (txLevel == LW'(DEPTH));
  assign txEmpty = (txLevel == '0);
  assign rxRdOk  = hostRdEn && (hostAddr == ADDR_RX) && !rxEmpty;

  always_comb begin
    stb.clear  = fifoClear;
    stb.rxPush = !fifoClear && cardRxPush && !rxFull;
    stb.rxPop  = !fifoClear && rxRdOk;
    stb.txPush = !fifoClear && hostWrEn && (hostAddr == ADDR_TX) && !txFull;
    stb.txPop  = !fifoClear && cardTxPop && !txEmpty;
    stb.rdZero = fifoClear || (hostRdEn && !rxRdOk);
  end

  function automatic logic [STAT_W-1:0] flags(input logic [LW-1:0] n);
    logic [STAT_W-1:0] s;
    s = '0;
    s[FULL_BIT]  = (n == LW'(DEPTH));
    s[EMPTY_BIT] = (n == '0);
    s[AFULL_BIT] = (n >= LW'(AFULL));
    return s;
  endfunction

  assign rxStatus = flags(rxLevel);
  assign txStatus = flags(txLevel);
  assign rxReq    = (rxLevel >= LW'(BURST)) || (endOfXfer && !rxEmpty);
  assign txReq    = (txLevel < LW'(BURST));

  // R1: a clear leaves both queues empty on the next cycle
  assert_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    fifoClear |=> (rxLevel == '0 && txLevel == '0));
  // R9: a full receive queue keeps its level under a card push without a read
  assert_rx_full_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && cardRxPush && !hostRdEn && !fifoClear) |=> (rxLevel == LW'(DEPTH)));
  // R11: a host write at the receive address never moves the transmit level
  assert_wrong_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == ADDR_RX && !cardTxPop && !fifoClear) |=> $stable(txLevel));
endmodule

// File: rtl/burst_fifo_pair.sv
module burst_fifo_pair
  import bfifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int BURST  = DEPTH / 2,
  parameter int AFULL  = DEPTH - 1,
  parameter int STAT_W = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoClear,
  input  logic              cardRxPush,
  input  logic [DATA_W-1:0] cardRxData,
  input  logic              cardTxPop,
  output logic [DATA_W-1:0] cardTxData,
  input  logic              hostRdEn,
  input  logic              hostWrEn,
  input  logic              hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              endOfXfer,
  output logic              rxReq,
  output logic              txReq,
  output logic [STAT_W-1:0] rxStatus,
  output logic [STAT_W-1:0] txStatus,
  output logic [LW-1:0]     rxLevel,
  output logic [LW-1:0]     txLevel
);
  fifoStrobes_t stb;

  fifo_ctrl #(.DEPTH(DEPTH), .BURST(BURST), .AFULL(AFULL), .STAT_W(STAT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .fifoClear(fifoClear),
    .cardRxPush(cardRxPush), .cardTxPop(cardTxPop),
    .hostRdEn(hostRdEn), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .endOfXfer(endOfXfer), .rxLevel(rxLevel), .txLevel(txLevel),
    .stb(stb), .rxReq(rxReq), .txReq(txReq),
    .rxStatus(rxStatus), .txStatus(txStatus)
  );

  fifo_dp #(.W(DATA_W), .DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cardRxData(cardRxData), .hostWrData(hostWrData),
    .cardTxData(cardTxData), .hostRdData(hostRdData),
    .rxLevel(rxLevel), .txLevel(txLevel)
  );
endmodule

// File: tb/test_burst_fifo_pair.sv
module test_burst_fifo_pair;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fifoClear = 0, cardRxPush = 0, cardTxPop = 0;
  logic        hostRdEn = 0, hostWrEn = 0, hostAddr = 0, endOfXfer = 0;
  logic [31:0] cardRxData = 0, hostWrData = 0;
  logic [31:0] cardTxData, hostRdData;
  logic        rxReq, txReq;
  logic [15:0] rxStatus, txStatus;
  logic [4:0]  rxLevel, txLevel;

  int checks = 0;
  int errors = 0;
  logic [31:0] rxQ[$];
  logic [31:0] txQ[$];
  logic [31:0] expRd = 0;

  always #2 clk = ~clk;

  burst_fifo_pair i_burst_fifo_pair (
    .clk(clk), .rstN(rstN), .fifoClear(fifoClear),
    .cardRxPush(cardRxPush), .cardRxData(cardRxData),
    .cardTxPop(cardTxPop), .cardTxData(cardTxData),
    .hostRdEn(hostRdEn), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .endOfXfer(endOfXfer), .rxReq(rxReq), .txReq(txReq),
    .rxStatus(rxStatus), .txStatus(txStatus),
    .rxLevel(rxLevel), .txLevel(txLevel)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expFlags(int n);
    logic [15:0] s = '0;
    s[7]  = (n == 16);
    s[6]  = (n == 0);
    s[10] = (n >= 15);
    return s;
  endfunction

  task automatic compareAll(string tag);
    int nr = rxQ.size();
    int nt = txQ.size();
    check({tag, " R2 rx level"}, 32'(rxLevel), 32'(nr));
    check({tag, " R3 tx level"}, 32'(txLevel), 32'(nt));
    check({tag, " R4 R6 rxReq"}, 32'(rxReq), 32'((nr >= 8) || (endOfXfer && nr > 0)));
    check({tag, " R5 txReq"}, 32'(txReq), 32'(nt < 8));
    check({tag, " R7 rx status"}, 32'(rxStatus), 32'(expFlags(nr)));
    check({tag, " R7 tx status"}, 32'(txStatus), 32'(expFlags(nt)));
    check({tag, " R10 read data"}, hostRdData, expRd);
    check({tag, " R3 tx head"}, cardTxData, (nt > 0) ? txQ[0] : 32'h0);
  endtask

  // drive one cycle at a negedge, update the model, then check at the next negedge
  task automatic cycle(string tag, logic clr, logic rxP, logic [31:0] rxD, logic txP,
                       logic rd, logic wr, logic addr, logic [31:0] wd, logic eox);
    int nr = rxQ.size();
    int nt = txQ.size();
    fifoClear = clr; cardRxPush = rxP; cardRxData = rxD; cardTxPop = txP;
    hostRdEn = rd; hostWrEn = wr; hostAddr = addr; hostWrData = wd; endOfXfer = eox;
    if (clr) begin
      rxQ.delete(); txQ.delete(); expRd = 0;
    end else begin
      if (rd) begin
        if (!addr && nr > 0) expRd = rxQ.pop_front();
        else expRd = 0;
      end
      if (rxP && nr < 16) rxQ.push_back(rxD);
      if (txP && nt > 0) void'(txQ.pop_front());
      if (wr && addr && nt < 16) txQ.push_back(wd);
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 reset");

    // R9: overfill the receive queue, then the transmit queue
    for (int i = 0; i < 18; i++) cycle("R9 rx fill", 0, 1, 32'hA000 + i, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 18; i++) cycle("R9 tx fill", 0, 0, 0, 0, 0, 1, 1, 32'hB000 + i, 0);
    // R9: push while full with a concurrent read: push dropped
    cycle("R9 full push+read", 0, 1, 32'hDEAD, 0, 1, 0, 0, 0, 0);
    // R11: wrong-address accesses
    cycle("R11 write rx addr", 0, 0, 0, 0, 0, 1, 0, 32'hBAD0, 0);
    cycle("R11 read tx addr", 0, 0, 0, 0, 1, 0, 1, 0, 0);
    // R1: clear
    cycle("R1 clear", 1, 1, 32'h1, 1, 1, 1, 1, 32'h2, 0);
    // R8: read empty receive queue
    cycle("R8 empty read", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    // R9: pop of empty transmit queue
    cycle("R9 empty pop", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    // R6: short tail drained under end-of-transfer
    for (int i = 0; i < 3; i++) cycle("R6 tail push", 0, 1, 32'hC000 + i, 0, 0, 0, 0, 0, 0);
    cycle("R6 eox on", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 4; i++) cycle("R6 eox drain", 0, 0, 0, 0, 1, 0, 0, 0, 1);
    cycle("R6 eox idle", 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // random phases alternating fill-heavy and drain-heavy
    for (int c = 0; c < 4000; c++) begin
      bit fill = ((c / 150) % 2) == 0;
      int pIn = fill ? 75 : 25;
      logic rxP = ($urandom % 100) < pIn;
      logic txP = ($urandom % 100) >= pIn;
      int hsel = $urandom % 100;
      logic rd = 0, wr = 0, addr = 0;
      if (hsel < 45) begin rd = 1; addr = ($urandom % 8) == 0; end
      else if (hsel < 90) begin wr = 1; addr = ($urandom % 8) != 0; end
      if (fill && rd && !addr && ($urandom % 2) == 0) rd = 0;
      cycle("rand", ($urandom % 500) == 0, rxP, $urandom, txP, rd, wr, addr, $urandom,
            ($urandom % 10) == 0);
    end
    finishRun();
  end
endmodule